// File: doc/BRIEF.md
# Display Shift Address Mapper

This block sits between the display scan sequencer and the display data memory of a character display controller. For every visible character position the scan presents, it returns the memory address whose character code should be fetched. A software-visible shift command slides the whole visible window one character left or right. A clear or return-home command puts the window back at its origin.

The block keeps a single shift offset that all lines share, so the lines always move together. The offset is held modulo the full address span of a single-line wide layout, which is 80. In the two-line and the narrow single-line layouts, each line takes the offset modulo its own 40-entry window. As a result, a line that scrolls past the end of its window wraps back to the start of that same window and never spills into the other line. The wide 32-character layout has no defined shift wrap. The block therefore raises a flag whenever the visible window would show the last and the first address of the 80-entry span at the same time.

Top module: `dsm_shift_mapper`

## Requirements
- R1: While and after reset, the shift offset is zero, addr_valid is 0 and wrap_hazard is 0.
- R2: In wide mode (mode = 2'b00) with zero offset, column c (0 to 31) maps to address c.
- R3: In two-line mode (mode = 2'b01, and 2'b11 behaves the same) with zero offset, line 0 column c maps to c and line 1 column c maps to 40h + c. Only the low 4 bits of pos_col are used.
- R4: In narrow mode (mode = 2'b10), pos_line is ignored. Column c (low 4 bits) maps to (c + offset mod 40) mod 40, always below 28h.
- R5: A shift command with shift_left = 1 adds one to the offset. After one left shift from origin, column 0 shows 01h on line 0 and 41h on line 1.
- R6: A shift command with shift_left = 0 subtracts one from the offset, modulo 80. After one right shift from origin, column 0 shows 27h on line 0 and 67h on line 1.
- R7: In two-line mode each line wraps inside its own window: line 0 addresses stay within 00h to 27h (27h is followed by 00h), and line 1 addresses stay within 40h to 67h (67h is followed by 40h).
- R8: In wide mode, column c maps to (c + offset) mod 80, always below 50h.
- R9: wrap_hazard is 1 exactly when the mode is wide and the offset is 49 to 79, meaning both 4Fh and 00h are visible. It is updated on the clock edge that samples the shift command or the mode.
- R10: home_req sets the offset to zero on the edge that samples it and takes priority over a shift command in the same cycle.
- R11: addr and addr_valid are registered one cycle after pos_valid. A position sampled in the same cycle as a shift or home command uses the offset from before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Layout: 00 wide single line, 01/11 two lines, 10 narrow single line |
| shift_req | input | 1 | One-cycle shift command |
| shift_left | input | 1 | Shift direction: 1 left (offset +1), 0 right (offset -1) |
| home_req | input | 1 | Clear or return-home pulse, resets the offset |
| pos_valid | input | 1 | Scan position presented this cycle |
| pos_line | input | 1 | Line index of the scan position |
| pos_col | input | 5 | Column index of the scan position |
| addr_valid | output | 1 | Registered copy of pos_valid |
| addr | output | 7 | Display memory address for the sampled position |
| wrap_hazard | output | 1 | Wide-mode window shows both ends of the address span |

## Verification
Full column scans at the origin in every layout separate the base mapping of each line, and they show that the line bit is ignored in narrow mode. Single left and right shifts, followed by scans of the first columns, expose an off-by-one or wrong-direction offset and any wrap that leaks across lines. Walking the offset through 48, 49 and 79 in wide mode pins down the hazard threshold. Same-cycle home-plus-shift and shift-plus-position patterns, along with a long pseudo-random mix of mode changes, check command priority and latency against the reference model.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  typedef enum logic [1:0] {
    MODE_WIDE     = 2'b00,
    MODE_DUAL     = 2'b01,
    MODE_NARROW   = 2'b10,
    MODE_DUAL_ALT = 2'b11
  } scan_mode_e;

  function automatic logic is_dual(input scan_mode_e m);
    return (m == MODE_DUAL) || (m == MODE_DUAL_ALT);
  endfunction

endpackage

// File: rtl/dsm_offset.sv
module dsm_offset #(
  parameter int FULL_LEN = 80,
  parameter int OW       = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          home_req,
  input  logic          shift_req,
  input  logic          shift_left,
  output logic [OW-1:0] off_q,
  output logic [OW-1:0] off_nxt
);

  localparam logic [OW-1:0] LAST = OW'(FULL_LEN - 1);

  always_comb begin
    off_nxt = off_q;
    if (home_req) begin
      off_nxt = '0;
    end else if (shift_req) begin
      if (shift_left) off_nxt = (off_q == LAST) ? '0 : off_q + 1'b1;
      else            off_nxt = (off_q == '0) ? LAST : off_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) off_q <= '0;
    else     off_q <= off_nxt;
  end

endmodule

// File: rtl/dsm_map.sv
module dsm_map
  import dsm_pkg::*;
#(
  parameter int LINE_LEN    = 40,
  parameter int FULL_LEN    = 80,
  parameter int LINE2_BASE  = 64,
  parameter int NARROW_COLS = 16,
  parameter int CW          = 5,
  parameter int OW          = 7,
  parameter int AW          = 7
) (
  input  scan_mode_e    mode,
  input  logic          line,
  input  logic [CW-1:0] col,
  input  logic [OW-1:0] off,
  output logic [AW-1:0] addr
);

  localparam int SW  = OW + 1;
  localparam int NCB = $clog2(NARROW_COLS);
  localparam logic [SW-1:0] LEN_LINE = SW'(LINE_LEN);
  localparam logic [SW-1:0] LEN_FULL = SW'(FULL_LEN);

  logic          wide;
  logic          upper;
  logic [SW-1:0] eoff, colx, len, sum, wrapped;

  always_comb begin
    wide  = (mode == MODE_WIDE);
    upper = is_dual(mode) && line;
    len   = wide ? LEN_FULL : LEN_LINE;
    eoff  = {1'b0, off};
    if (!wide && eoff >= LEN_LINE) eoff = eoff - LEN_LINE;
    colx  = wide ? SW'(col) : SW'(col[NCB-1:0]);
    sum   = colx + eoff;
    wrapped = (sum >= len) ? sum - len : sum;
    addr  = AW'(wrapped) + (upper ? AW'(LINE2_BASE) : '0);
  end

endmodule

// File: rtl/dsm_guard.sv
module dsm_guard
  import dsm_pkg::*;
#(
  parameter int FULL_LEN  = 80,
  parameter int WIDE_COLS = 32,
  parameter int OW        = 7
) (
  input  scan_mode_e    mode,
  input  logic [OW-1:0] off,
  output logic          hazard
);

  localparam logic [OW-1:0] FIRST_BAD = OW'(FULL_LEN - WIDE_COLS + 1);

  always_comb hazard = (mode == MODE_WIDE) && (off >= FIRST_BAD);

endmodule

// File: rtl/dsm_shift_mapper.sv
module dsm_shift_mapper
  import dsm_pkg::*;
#(
  parameter int LINE_LEN    = 40,
  parameter int NUM_LINES   = 2,
  parameter int LINE2_BASE  = 64,
  parameter int WIDE_COLS   = 32,
  parameter int NARROW_COLS = 16,
  parameter int ADDR_W      = 7,
  localparam int FULL_LEN   = LINE_LEN * NUM_LINES,
  localparam int OW         = $clog2(FULL_LEN),
  localparam int CW         = $clog2(WIDE_COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              shift_req,
  input  logic              shift_left,
  input  logic              home_req,
  input  logic              pos_valid,
  input  logic              pos_line,
  input  logic [CW-1:0]     pos_col,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr,
  output logic              wrap_hazard
);

  scan_mode_e        mode_e;
  logic [OW-1:0]     off_q, off_nxt;
  logic [ADDR_W-1:0] map_addr;
  logic              haz_nxt;

  assign mode_e = scan_mode_e'(mode);

  dsm_offset #(.FULL_LEN(FULL_LEN), .OW(OW)) u_off (
    .clk(clk), .rst(rst), .home_req(home_req), .shift_req(shift_req),
    .shift_left(shift_left), .off_q(off_q), .off_nxt(off_nxt)
  );

  dsm_map #(
    .LINE_LEN(LINE_LEN), .FULL_LEN(FULL_LEN), .LINE2_BASE(LINE2_BASE),
    .NARROW_COLS(NARROW_COLS), .CW(CW), .OW(OW), .AW(ADDR_W)
  ) u_map (
    .mode(mode_e), .line(pos_line), .col(pos_col), .off(off_q), .addr(map_addr)
  );

  dsm_guard #(.FULL_LEN(FULL_LEN), .WIDE_COLS(WIDE_COLS), .OW(OW)) u_guard (
    .mode(mode_e), .off(off_nxt), .hazard(haz_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_valid  <= 1'b0;
      addr        <= '0;
      wrap_hazard <= 1'b0;
    end else begin
      addr_valid  <= pos_valid;
      if (pos_valid) addr <= map_addr;
      wrap_hazard <= haz_nxt;
    end
  end

endmodule

// File: rtl/dsm_checker.sv
module dsm_checker #(
  parameter int LINE_LEN   = 40,
  parameter int FULL_LEN   = 80,
  parameter int LINE2_BASE = 64,
  parameter int ADDR_W     = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode,
  input logic              home_req,
  input logic              pos_valid,
  input logic              addr_valid,
  input logic [ADDR_W-1:0] addr,
  input logic              wrap_hazard
);

  localparam logic [ADDR_W-1:0] L0_LAST = ADDR_W'(LINE_LEN - 1);
  localparam logic [ADDR_W-1:0] L1_FIRST = ADDR_W'(LINE2_BASE);
  localparam logic [ADDR_W-1:0] L1_LAST = ADDR_W'(LINE2_BASE + LINE_LEN - 1);
  localparam logic [ADDR_W-1:0] WIDE_END = ADDR_W'(FULL_LEN - 1);

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    pos_valid |=> addr_valid);

  // R11
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !pos_valid |=> !addr_valid);

  // R7
  dual_window_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && $past(mode[0])) |->
      (addr <= L0_LAST) || (addr >= L1_FIRST && addr <= L1_LAST));

  // R4
  narrow_window_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && $past(mode) == 2'b10) |-> addr <= L0_LAST);

  // R8
  wide_window_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && $past(mode) == 2'b00) |-> addr <= WIDE_END);

  // R9
  hazard_mode_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_hazard |-> $past(mode) == 2'b00);

  // R10
  home_clears_chk: assert property (@(posedge clk) disable iff (rst)
    home_req |=> !wrap_hazard);

endmodule

bind dsm_shift_mapper dsm_checker #(
  .LINE_LEN(LINE_LEN), .FULL_LEN(FULL_LEN), .LINE2_BASE(LINE2_BASE), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .home_req(home_req), .pos_valid(pos_valid),
  .addr_valid(addr_valid), .addr(addr), .wrap_hazard(wrap_hazard)
);

// File: tb/dsm_shift_mapper_test.sv
module dsm_shift_mapper_test;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] mode;
  logic       shift_req, shift_left, home_req, pos_valid, pos_line;
  logic [4:0] pos_col;
  logic       addr_valid, wrap_hazard;
  logic [6:0] addr;

  int n_checks = 0;
  int n_fail   = 0;

  // reference state
  int    ref_off  = 0;
  int    exp_addr = 0;
  bit    exp_valid = 0;
  bit    exp_haz = 0;
  string exp_tag = "R1";

  always #5 clk = ~clk;

  dsm_shift_mapper uut (
    .clk(clk), .rst(rst), .mode(mode), .shift_req(shift_req),
    .shift_left(shift_left), .home_req(home_req), .pos_valid(pos_valid),
    .pos_line(pos_line), .pos_col(pos_col), .addr_valid(addr_valid),
    .addr(addr), .wrap_hazard(wrap_hazard)
  );

  function automatic int ref_map(int m, int ln, int c, int off);
    if (m == 0) return (c + off) % 80;
    begin
      int eo = off % 40;
      int cc = c % 16;
      int base = (m == 2) ? 0 : (ln ? 64 : 0);
      return base + (cc + eo) % 40;
    end
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    check(exp_tag == "R1" ? "R1" : "R11", int'(addr_valid), int'(exp_valid));
    check(exp_tag == "R1" ? "R1" : "R9", int'(wrap_hazard), int'(exp_haz));
    if (exp_valid) check(exp_tag, int'(addr), exp_addr);
  endtask

  task automatic step(input int m, input bit sh, input bit lf, input bit hm,
                      input bit pv, input bit ln, input int c, input string tag);
    @(negedge clk);
    compare();
    mode = 2'(m); shift_req = sh; shift_left = lf; home_req = hm;
    pos_valid = pv; pos_line = ln; pos_col = 5'(c);
    exp_valid = pv;
    if (pv) exp_addr = ref_map(m, ln, c, ref_off);
    if (hm) ref_off = 0;
    else if (sh) ref_off = lf ? (ref_off + 1) % 80 : (ref_off + 79) % 80;
    exp_haz = (m == 0) && (ref_off >= 49);
    exp_tag = tag;
  endtask

  task automatic scan(input int m, input bit ln, input int c, input string tag);
    step(m, 0, 0, 0, 1, ln, c, tag);
  endtask

  task automatic shift(input int m, input bit lf, input string tag);
    step(m, 1, lf, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 10);
    n_checks++; n_fail++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int lfsr = 32'h1ACE;
    rst = 1'b1; mode = 0; shift_req = 0; shift_left = 0; home_req = 0;
    pos_valid = 0; pos_line = 0; pos_col = 0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared during reset
    check("R1", int'(addr_valid), 0);
    check("R1", int'(wrap_hazard), 0);
    rst = 1'b0;
    // R1: offset zero after reset, first position maps to origin
    scan(0, 0, 0, "R1");
    // R2: wide mode origin scan
    for (int c = 0; c < 32; c++) scan(0, 0, c, "R2");
    // R3: two-line origin scan, both encodings
    for (int c = 0; c < 16; c++) begin
      scan(1, 0, c, "R3");
      scan(1, 1, c, "R3");
    end
    scan(3, 1, 5, "R3");
    scan(1, 1, 21, "R3");
    // R4: narrow mode ignores line bit
    for (int c = 0; c < 16; c++) scan(2, 1, c, "R4");
    // R5: one left shift
    shift(1, 1, "R5");
    scan(1, 0, 0, "R5");
    scan(1, 1, 0, "R5");
    scan(0, 0, 31, "R5");
    // R10 then R6: back to origin, one right shift
    step(1, 0, 0, 1, 0, 0, 0, "R10");
    scan(1, 0, 0, "R10");
    shift(1, 0, "R6");
    scan(1, 0, 0, "R6");
    scan(1, 1, 0, "R6");
    // R7: wrap stays within each line
    scan(1, 0, 1, "R7");
    scan(1, 1, 1, "R7");
    scan(2, 0, 1, "R4");
    // R8/R9: wide mode at offset 79
    scan(0, 0, 0, "R8");
    scan(0, 0, 1, "R8");
    // R10: home wins over shift in the same cycle
    step(0, 1, 1, 1, 0, 0, 0, "R10");
    scan(0, 0, 0, "R10");
    // R9: walk to threshold 48 then 49
    for (int i = 0; i < 48; i++) shift(0, 1, "R9");
    scan(0, 0, 31, "R8");
    shift(0, 1, "R9");
    scan(0, 0, 31, "R8");
    scan(0, 0, 30, "R8");
    // R11: position in the same cycle as a shift uses the old offset
    step(0, 1, 0, 0, 1, 0, 0, "R11");
    scan(0, 0, 0, "R11");
    // R7: offset 48 viewed in two-line mode (48 mod 40 = 8)
    scan(1, 1, 15, "R7");
    scan(1, 0, 15, "R7");
    // mixed pseudo-random traffic
    for (int i = 0; i < 3000; i++) begin
      int m, c;
      bit sh, lf, hm, ln, pv;
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      m  = lfsr & 3;
      sh = ((lfsr >> 2) & 3) == 0;
      lf = (lfsr >> 4) & 1;
      hm = ((lfsr >> 5) & 63) == 0;
      pv = ((lfsr >> 11) & 3) != 0;
      ln = (lfsr >> 13) & 1;
      c  = (lfsr >> 6) & 31;
      step(m, sh, lf, hm, pv, ln, c,
           m == 0 ? "R8" : (m == 2 ? "R4" : "R7"));
    end
    step(0, 0, 0, 0, 0, 0, 0, "R11");
    @(negedge clk);
    compare();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule